// File: doc/BRIEF.md
# Load-use hazard stall controller

This block sits at the front of a five-stage in-order pipeline. A load result only arrives after the memory stage, so an instruction that reads the loaded register straight after the load cannot get that value through forwarding in time. The block watches the load's destination register number in the execute-stage register and the two source register fields of the instruction in the decode-stage register. When they collide, the block holds the program counter and the decode-stage register for one cycle. It also writes all-zero controls into the execute-stage register, which inserts a no-op bubble while the load carries on into the memory stage.

The pipeline state the block acts on is part of the block: the program counter, the decode-stage instruction register and the control fields of the later stage registers. This lets the stall be observed cycle by cycle at the ports. The instruction memory and the decoder are outside the block. It drives `pc` to fetch `fetch_word`, and the decoder returns `dec_ctrl` for the instruction held in `ifid_word`. Control bit 0 is the memory-read flag, bit 1 the memory-write flag and bit 2 the register-write flag. The source register fields sit at bits [25:21] and [20:16] of the instruction word.

Top module: `loaduse_stall_ctl`

## Requirements
- R1: A stall is raised when the execute-stage control has bit 0 (memory read) set and the execute-stage destination number `idex_rt` equals bits [25:21] of `ifid_word`.
- R2: A stall is likewise raised when that load's `idex_rt` equals bits [20:16] of `ifid_word`.
- R3: No stall occurs when the execute-stage instruction is not a load, even if its register numbers match, or when a load's destination matches neither source field. During a stall `pc_write` and `ifid_write` are low and `idex_flush` is high; otherwise `pc_write` and `ifid_write` are high and `idex_flush` is low.
- R4: On a stall edge `pc` keeps its value; on every other edge after reset it advances by 4.
- R5: On a stall edge `ifid_word` keeps its value; on every other edge it takes `fetch_word`.
- R6: On a stall edge `idex_ctrl` and `idex_rt` become zero. On every other edge they take `dec_ctrl` unchanged and bits [20:16] of `ifid_word`.
- R7: The load is not held: on the stall edge its controls move from `idex_ctrl` into `exmem_ctrl`.
- R8: Each load-use pair causes exactly one stall cycle, and the stall is never high in two consecutive cycles.
- R9: The bubble's zero controls pass through `exmem_ctrl` and then `memwb_ctrl`, so it never asserts memory write or register write in a later stage.
- R10: A synchronous active-high `rst` clears `pc`, `ifid_word`, `idex_rt` and all stage control registers to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_word | input | 32 | Instruction word read at `pc` |
| dec_ctrl | input | 8 | Decoded controls of the instruction in `ifid_word` |
| pc | output | 32 | Program counter |
| ifid_word | output | 32 | Decode-stage instruction register |
| idex_ctrl | output | 8 | Execute-stage control fields |
| idex_rt | output | 5 | Execute-stage destination register number of a load |
| exmem_ctrl | output | 8 | Memory-stage control fields |
| memwb_ctrl | output | 8 | Write-back-stage control fields |
| pc_write | output | 1 | Program counter update enable |
| ifid_write | output | 1 | Decode-stage register update enable |
| idex_flush | output | 1 | Zeroes the controls written into the execute stage |

## Verification
The hardest situation to reach is a second load-use pair arriving right after a stall. In that case the instruction that was held in decode is itself a load, and the next instruction reads its result. This tests that the bubble cleanly ends the first stall and that the second hazard is still caught one cycle later. The stimulus gets there with short programs of chained loads, where each load takes its base register from the previous load. These programs are mixed with cases that must not stall: a load followed by an instruction using other registers, a load reused two slots later, and a non-load writer followed at once by a reader.

// File: rtl/loaduse_stall_ctl.sv
module loaduse_stall_ctl #(
  parameter int PC_W    = 32,
  parameter int IW      = 32,
  parameter int CW      = 8,
  parameter int RW      = 5,
  parameter int RS_LSB  = 21,
  parameter int RT_LSB  = 16,
  parameter int MRD_BIT = 0,
  parameter int PC_STEP = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [IW-1:0]   fetch_word,
  input  logic [CW-1:0]   dec_ctrl,
  output logic [PC_W-1:0] pc,
  output logic [IW-1:0]   ifid_word,
  output logic [CW-1:0]   idex_ctrl,
  output logic [RW-1:0]   idex_rt,
  output logic [CW-1:0]   exmem_ctrl,
  output logic [CW-1:0]   memwb_ctrl,
  output logic            pc_write,
  output logic            ifid_write,
  output logic            idex_flush
);

  localparam logic [PC_W-1:0] STEP = PC_W'(PC_STEP);

  logic [RW-1:0] id_rs, id_rt;
  logic          ex_is_load, collide;

  assign id_rs      = ifid_word[RS_LSB +: RW];
  assign id_rt      = ifid_word[RT_LSB +: RW];
  assign ex_is_load = idex_ctrl[MRD_BIT];
  assign collide    = (idex_rt == id_rs) || (idex_rt == id_rt);

  assign idex_flush = ex_is_load && collide;
  assign pc_write   = !idex_flush;
  assign ifid_write = !idex_flush;

  always_ff @(posedge clk) begin
    if (rst)           pc <= '0;
    else if (pc_write) pc <= pc + STEP;
  end

  always_ff @(posedge clk) begin
    if (rst)             ifid_word <= '0;
    else if (ifid_write) ifid_word <= fetch_word;
  end

  always_ff @(posedge clk) begin
    if (rst || idex_flush) begin
      idex_ctrl <= '0;
      idex_rt   <= '0;
    end else begin
      idex_ctrl <= dec_ctrl;
      idex_rt   <= id_rt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      exmem_ctrl <= '0;
      memwb_ctrl <= '0;
    end else begin
      exmem_ctrl <= idex_ctrl;
      memwb_ctrl <= exmem_ctrl;
    end
  end

endmodule

// File: rtl/loaduse_stall_chk.sv
module loaduse_stall_chk #(
  parameter int PC_W    = 32,
  parameter int IW      = 32,
  parameter int CW      = 8,
  parameter int MRD_BIT = 0,
  parameter int PC_STEP = 4
) (
  input logic            clk,
  input logic            rst,
  input logic [PC_W-1:0] pc,
  input logic [IW-1:0]   ifid_word,
  input logic [CW-1:0]   idex_ctrl,
  input logic [CW-1:0]   exmem_ctrl,
  input logic [CW-1:0]   memwb_ctrl,
  input logic            pc_write,
  input logic            ifid_write,
  input logic            idex_flush
);

  AST_STALL_NEEDS_LOAD: assert property (@(posedge clk) disable iff (rst)
    idex_flush |-> idex_ctrl[MRD_BIT]);                                      // R3
  AST_ENABLES_AGREE: assert property (@(posedge clk) disable iff (rst)
    (pc_write == ifid_write) && (idex_flush != pc_write));                  // R3
  AST_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
    !pc_write |=> pc == $past(pc));                                         // R4
  AST_PC_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    pc_write |=> pc == $past(pc) + PC_W'(PC_STEP));                         // R4
  AST_IFID_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ifid_write |=> ifid_word == $past(ifid_word));                         // R5
  AST_BUBBLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    idex_flush |=> idex_ctrl == '0);                                        // R6
  AST_LOAD_ADVANCES: assert property (@(posedge clk) disable iff (rst)
    idex_flush |=> exmem_ctrl == $past(idex_ctrl));                         // R7
  AST_SINGLE_STALL: assert property (@(posedge clk) disable iff (rst)
    idex_flush |=> !idex_flush);                                            // R8
  AST_BUBBLE_FLOWS: assert property (@(posedge clk) disable iff (rst)
    (exmem_ctrl == '0) |=> memwb_ctrl == '0);                               // R9
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (pc == '0) && (idex_ctrl == '0) && (memwb_ctrl == '0));         // R10

endmodule

bind loaduse_stall_ctl loaduse_stall_chk #(
  .PC_W(PC_W), .IW(IW), .CW(CW), .MRD_BIT(MRD_BIT), .PC_STEP(PC_STEP)
) u_chk (
  .clk(clk), .rst(rst), .pc(pc), .ifid_word(ifid_word),
  .idex_ctrl(idex_ctrl), .exmem_ctrl(exmem_ctrl), .memwb_ctrl(memwb_ctrl),
  .pc_write(pc_write), .ifid_write(ifid_write), .idex_flush(idex_flush)
);

// File: tb/loaduse_stall_ctl_bench.sv
module loaduse_stall_ctl_bench;

  typedef struct packed {
    logic        stall;
    logic [31:0] pc;
    logic [31:0] ifid;
    logic [7:0]  idex;
    logic [4:0]  rt;
    logic [7:0]  exmem;
    logic [7:0]  memwb;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] fetch_word;
  logic [7:0]  dec_ctrl;
  logic [31:0] pc, ifid_word;
  logic [7:0]  idex_ctrl, exmem_ctrl, memwb_ctrl;
  logic [4:0]  idex_rt;
  logic        pc_write, ifid_write, idex_flush;

  int checks = 0;
  int errors = 0;
  logic [31:0] prog [16];
  int prog_len = 0;
  exp_t sb[$];
  int slots[$];
  logic prev_stall = 1'b0;

  always #4 clk = ~clk;

  loaduse_stall_ctl u_loaduse_stall_ctl (
    .clk(clk), .rst(rst), .fetch_word(fetch_word), .dec_ctrl(dec_ctrl),
    .pc(pc), .ifid_word(ifid_word), .idex_ctrl(idex_ctrl), .idex_rt(idex_rt),
    .exmem_ctrl(exmem_ctrl), .memwb_ctrl(memwb_ctrl),
    .pc_write(pc_write), .ifid_write(ifid_write), .idex_flush(idex_flush)
  );

  function automatic logic [31:0] word_at(int j);
    return (j >= 0 && j < prog_len) ? prog[j] : 32'h0;
  endfunction

  function automatic logic [7:0] ctrl_of(logic [31:0] w);
    if (w == 32'h0) return 8'h00;
    case (w[31:26])
      6'h23:   return 8'h1D;
      6'h2B:   return 8'h12;
      6'h08:   return 8'h34;
      default: return 8'h24;
    endcase
  endfunction

  function automatic logic [31:0] mk(logic [5:0] op, int rs, int rt, int rd);
    return {op, rs[4:0], rt[4:0], rd[4:0], 11'h0};
  endfunction

  always_comb fetch_word = word_at(int'(pc >> 2));
  always_comb dec_ctrl   = ctrl_of(ifid_word);

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic [31:0] slot_word(int k);
    if (k < 0 || k >= slots.size() || slots[k] < 0) return 32'h0;
    return word_at(slots[k]);
  endfunction

  task automatic run_prog();
    logic [31:0] prev;
    int real_cnt;
    @(negedge clk); rst <= 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R10 pc", pc, 0);
    check("R10 ifid", ifid_word, 0);
    check("R10 idex", {24'h0, idex_ctrl}, 0);
    check("R10 exmem/memwb", {16'h0, exmem_ctrl, memwb_ctrl}, 0);
    check("R10 pc_write", {31'h0, pc_write}, 1);
    slots.delete();
    prev = 32'h0;
    for (int i = 0; i < prog_len + 3; i++) begin
      logic [31:0] w;
      w = word_at(i);
      if (ctrl_of(prev)[0] && (prev[20:16] == w[25:21] || prev[20:16] == w[20:16]))
        slots.push_back(-1);
      slots.push_back(i);
      prev = w;
    end
    for (int e = 1; e <= slots.size() + 2; e++) begin
      exp_t r;
      real_cnt = 0;
      for (int k = 0; k <= e - 2; k++)
        if (k >= slots.size() || slots[k] >= 0) real_cnt++;
      r.stall = (e - 1 < slots.size()) && (slots[e-1] < 0);
      r.pc    = 32'(4 * (real_cnt + 1));
      r.ifid  = word_at(real_cnt);
      r.idex  = ctrl_of(slot_word(e - 2));
      r.rt    = slot_word(e - 2)[20:16];
      r.exmem = ctrl_of(slot_word(e - 3));
      r.memwb = ctrl_of(slot_word(e - 4));
      sb.push_back(r);
    end
    @(negedge clk); rst <= 1'b0;
    wait (sb.size() == 0);
    @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (!rst && sb.size() > 0) begin
      exp_t r;
      r = sb.pop_front();
      check("R1,R2,R3 pc_write", {31'h0, pc_write}, {31'h0, !r.stall});
      check("R1,R2,R3 ifid_write", {31'h0, ifid_write}, {31'h0, !r.stall});
      check("R1,R2,R3 idex_flush", {31'h0, idex_flush}, {31'h0, r.stall});
      check("R4 pc", pc, r.pc);
      check("R5 ifid_word", ifid_word, r.ifid);
      check("R6 idex_ctrl", {24'h0, idex_ctrl}, {24'h0, r.idex});
      check("R6 idex_rt", {27'h0, idex_rt}, {27'h0, r.rt});
      check("R7 exmem_ctrl", {24'h0, exmem_ctrl}, {24'h0, r.exmem});
      check("R9 memwb_ctrl", {24'h0, memwb_ctrl}, {24'h0, r.memwb});
      check("R9 bubble writes", {30'h0, memwb_ctrl[2:1]}, {30'h0, r.memwb[2:1]});
      if (prev_stall) check("R8 back-to-back stall", {31'h0, idex_flush}, 0);
      prev_stall = idex_flush;
    end else begin
      prev_stall = 1'b0;
    end
  end

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    join_none

    // R1: load then reader on the first source field
    prog[0] = mk(6'h23, 1, 2, 0);
    prog[1] = mk(6'h00, 2, 5, 4);
    prog[2] = mk(6'h00, 6, 2, 8);
    prog[3] = mk(6'h00, 4, 2, 9);
    prog_len = 4;
    run_prog();

    // R2: load then reader on the second source field
    prog[0] = mk(6'h23, 1, 3, 0);
    prog[1] = mk(6'h00, 1, 3, 7);
    prog[2] = mk(6'h2B, 7, 3, 0);
    prog_len = 3;
    run_prog();

    // R3: independent follower, distance-two reader, non-load writer
    prog[0] = mk(6'h23, 1, 2, 0);
    prog[1] = mk(6'h00, 4, 5, 9);
    prog[2] = mk(6'h00, 2, 2, 10);
    prog[3] = mk(6'h08, 3, 2, 0);
    prog[4] = mk(6'h00, 2, 2, 11);
    prog[5] = mk(6'h2B, 6, 7, 0);
    prog[6] = mk(6'h00, 7, 6, 12);
    prog_len = 7;
    run_prog();

    // R8: chained loads, each stalls once
    prog[0] = mk(6'h23, 1, 2, 0);
    prog[1] = mk(6'h23, 2, 3, 0);
    prog[2] = mk(6'h00, 3, 3, 4);
    prog[3] = mk(6'h23, 4, 5, 0);
    prog[4] = mk(6'h2B, 5, 6, 0);
    prog[5] = mk(6'h23, 8, 9, 0);
    prog[6] = mk(6'h23, 9, 9, 0);
    prog[7] = mk(6'h00, 1, 9, 10);
    prog_len = 8;
    run_prog();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule